// File: doc/BRIEF.md
# Dual-Port 64-bit Control Register Bank

This block holds a small set of 64-bit control and status registers that can be reached over two independent paths. A sideband configuration port addresses registers by word (byte address divided by eight). A memory-mapped port uses its own byte address, shifted the same way and then offset by ten words, so that its window starts at the base-address register. Both ports move whole 64-bit words. The data bus is big-endian: bit 63 is the most significant bit and lies in byte lane 0.

Besides plain read/write registers, the bank offers alias addresses that do read-modify-write. One pair of aliases ANDs or ORs data into a fault register. A second pair sets or clears bits in a control register. A base-address register, which only the sideband port may write, drives the mapped-window base and its enable bit out to the rest of the chip. Each access is accepted through a valid/ready handshake. One cycle later an acknowledge returns on the same port, carrying read data and an error pulse.

Top module: `regbank_top`

## Requirements
- R1: After reset every register reads zero, except the base register (index 0x0A), which holds the `BASE_RESET` address with bit 0 (enable) set; `baseEn` is 1 and `baseAddr` equals `BASE_RESET`.
- R2: A sideband access targets register index `sbAddr>>3`. A memory-mapped access targets index `(mmAddr>>3)+0x0A`, so mapped byte 0x00 is the base register and mapped byte 0x20 is the control register (0x0E).
- R3: Writing index 0x00 loads the fault register. Writing index 0x01 ANDs the data into it, and writing index 0x02 ORs the data into it.
- R4: Writing index 0x0E loads the control register. Writing index 0x12 sets the control bits that are 1 in the data, and writing index 0x13 clears them.
- R5: A sideband write to the base register keeps only the bits of mask 0x0003fffffff00000 plus bit 0. `baseAddr` shows the masked address and `baseEn` shows bit 0.
- R6: A memory-mapped write to the base register changes nothing and is acknowledged with the error pulse.
- R7: The secondary base register (index 0x0B) keeps only the bits of mask 0x0003ffff00000000.
- R8: A read of any index that is not implemented (including the alias indices 0x01, 0x02, 0x12 and 0x13) returns all ones. A write there changes no register and raises no error.
- R9: The interrupt status register (index 0x15) reads zero. A write to it from either port changes nothing and is acknowledged with the error pulse.
- R10: `sbReady` is always 1 and `mmReady` is 1 only while `sbValid` is 0, so the sideband port wins a same-cycle conflict. An accepted access is acknowledged on its own port exactly one cycle later, and never on both ports at once. A write acknowledge carries zero data.
- R11: An error pulse appears only together with an acknowledge, and reads never raise it.
- R12: The general registers at indices 0x06, 0x07, 0x0F and 0x14 store and return all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sbValid | input | 1 | Sideband request valid |
| sbReady | output | 1 | Sideband request accepted |
| sbWrite | input | 1 | Sideband request is a write |
| sbAddr | input | SB_ADDR_W | Sideband byte address |
| sbWdata | input | 64 | Sideband write data |
| sbAck | output | 1 | Sideband response valid |
| sbRdata | output | 64 | Sideband read data |
| sbErr | output | 1 | Sideband access rejected |
| mmValid | input | 1 | Mapped request valid |
| mmReady | output | 1 | Mapped request accepted |
| mmWrite | input | 1 | Mapped request is a write |
| mmAddr | input | MM_ADDR_W | Mapped byte address within the window |
| mmWdata | input | 64 | Mapped write data |
| mmAck | output | 1 | Mapped response valid |
| mmRdata | output | 64 | Mapped read data |
| mmErr | output | 1 | Mapped access rejected |
| baseAddr | output | 64 | Masked base address of the mapped window |
| baseEn | output | 1 | Mapped window enable |

## Verification
The bench aims at the alias paths. If the AND, OR, set and clear aliases were decoded as plain stores, the fault and control values would come back overwritten instead of merged. It also reads the alias indices, where a design that stores the aliases as real registers would return data instead of all ones. The base register is written with all ones to catch a lost mask or a lost enable bit, and it is then attacked from the mapped port, where a missing port check would silently move the window. A same-cycle conflict, in which the sideband port writes the very register the mapped port reads, exposes a priority inversion: the mapped read would return the old value.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int DATA_W = 64;
  localparam int IDX_W  = 6;

  // register indices (word addresses)
  localparam logic [IDX_W-1:0] IDX_FAULT     = 6'h00;
  localparam logic [IDX_W-1:0] IDX_FAULT_AND = 6'h01;
  localparam logic [IDX_W-1:0] IDX_FAULT_OR  = 6'h02;
  localparam logic [IDX_W-1:0] IDX_BASE      = 6'h0A;
  localparam logic [IDX_W-1:0] IDX_SEC       = 6'h0B;
  localparam logic [IDX_W-1:0] IDX_CTL       = 6'h0E;
  localparam logic [IDX_W-1:0] IDX_CTL_SET   = 6'h12;
  localparam logic [IDX_W-1:0] IDX_CTL_CLR   = 6'h13;
  localparam logic [IDX_W-1:0] IDX_STAT      = 6'h15;

  // offset added to the mapped port word index
  localparam logic [IDX_W-1:0] MM_IDX_OFS = IDX_BASE;

  // general-purpose read/write registers
  localparam int NUM_PLAIN = 4;
  localparam logic [NUM_PLAIN-1:0][IDX_W-1:0] PLAIN_IDX = {6'h14, 6'h0F, 6'h07, 6'h06};

  localparam logic [DATA_W-1:0] BASE_MASK = 64'h0003_FFFF_FFF0_0000;
  localparam logic [DATA_W-1:0] SEC_MASK  = 64'h0003_FFFF_0000_0000;
  localparam int                BASE_EN_BIT = 0;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_AND,
    OP_OR,
    OP_ANDN
  } op_e;

  typedef struct packed {
    logic              take;
    logic              rd;
    op_e               op;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } strobe_t;

endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int SB_ADDR_W = 8,
  parameter int MM_ADDR_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sbValid,
  input  logic                 sbWrite,
  input  logic [SB_ADDR_W-1:0] sbAddr,
  input  logic [DATA_W-1:0]    sbWdata,
  input  logic                 mmValid,
  input  logic                 mmWrite,
  input  logic [MM_ADDR_W-1:0] mmAddr,
  input  logic [DATA_W-1:0]    mmWdata,
  output logic                 sbReady,
  output logic                 mmReady,
  output strobe_t              stb,
  output logic                 sbAck,
  output logic                 mmAck,
  output logic                 sbErr,
  output logic                 mmErr
);

  logic [IDX_W-1:0]  sbIdx, mmIdx, rawIdx;
  logic              grantSb, grantMm, isWr, reject;
  logic [DATA_W-1:0] wData;
  logic              unusedLowBits;

  // byte-lane bits below the word are not decoded
  assign unusedLowBits = ^{sbAddr[2:0], mmAddr[2:0]};

  assign sbIdx = IDX_W'(sbAddr[SB_ADDR_W-1:3]);
  assign mmIdx = IDX_W'(mmAddr[MM_ADDR_W-1:3]) + MM_IDX_OFS;

  // sideband port always wins
  assign sbReady = 1'b1;
  assign mmReady = ~sbValid;
  assign grantSb = sbValid;
  assign grantMm = mmValid & ~sbValid;

  always_comb begin
    rawIdx = grantSb ? sbIdx   : mmIdx;
    isWr   = grantSb ? sbWrite : mmWrite;
    wData  = grantSb ? sbWdata : mmWdata;
    reject = isWr & ((rawIdx == IDX_STAT) | ((rawIdx == IDX_BASE) & ~grantSb));

    stb      = '0;
    stb.take = grantSb | grantMm;
    stb.rd   = (grantSb | grantMm) & ~isWr;
    stb.idx  = rawIdx;
    stb.data = wData;
    stb.op   = OP_NONE;
    if ((grantSb | grantMm) & isWr & ~reject) begin
      unique case (rawIdx)
        IDX_FAULT_AND: begin stb.idx = IDX_FAULT; stb.op = OP_AND;  end
        IDX_FAULT_OR:  begin stb.idx = IDX_FAULT; stb.op = OP_OR;   end
        IDX_CTL_SET:   begin stb.idx = IDX_CTL;   stb.op = OP_OR;   end
        IDX_CTL_CLR:   begin stb.idx = IDX_CTL;   stb.op = OP_ANDN; end
        default:       stb.op = OP_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbAck <= 1'b0;
      mmAck <= 1'b0;
      sbErr <= 1'b0;
      mmErr <= 1'b0;
    end else begin
      sbAck <= grantSb;
      mmAck <= grantMm;
      sbErr <= grantSb & reject;
      mmErr <= grantMm & reject;
    end
  end

  // R10: each accepted request gets its acknowledge one cycle later
  a_r10_sb_acked: assert property (@(posedge clk) disable iff (!rstN)
    sbValid |=> sbAck);
  a_r10_mm_acked: assert property (@(posedge clk) disable iff (!rstN)
    (mmValid && !sbValid) |=> mmAck);
  a_r10_single_ack: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sbAck, mmAck}));
  // R11: error only travels with an acknowledge
  a_r11_sb_err_ack: assert property (@(posedge clk) disable iff (!rstN)
    sbErr |-> sbAck);
  a_r11_mm_err_ack: assert property (@(posedge clk) disable iff (!rstN)
    mmErr |-> mmAck);
  // R6: mapped write of the base register is flagged
  a_r6_mm_base_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (mmValid && !sbValid && mmWrite && mmIdx == IDX_BASE) |=> mmErr);

endmodule

// File: rtl/regbank_regs.sv
module regbank_regs
  import regbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] BASE_RESET = 64'h0000_0001_2340_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic [DATA_W-1:0] rdQ,
  output logic [DATA_W-1:0] baseAddr,
  output logic              baseEn
);

  localparam logic [DATA_W-1:0] BASE_KEEP = BASE_MASK | (DATA_W'(1) << BASE_EN_BIT);

  logic [DATA_W-1:0] faultQ, baseQ, secQ, ctlQ;
  logic [DATA_W-1:0] plainQ [NUM_PLAIN];
  logic [DATA_W-1:0] readVal;

  function automatic logic [DATA_W-1:0] merge(op_e op, logic [DATA_W-1:0] oldV,
                                              logic [DATA_W-1:0] newV);
    case (op)
      OP_LOAD: merge = newV;
      OP_AND:  merge = oldV & newV;
      OP_OR:   merge = oldV | newV;
      OP_ANDN: merge = oldV & ~newV;
      default: merge = oldV;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ <= '0;
      ctlQ   <= '0;
      secQ   <= '0;
      baseQ  <= (BASE_RESET & BASE_MASK) | (DATA_W'(1) << BASE_EN_BIT);
    end else if (stb.take) begin
      if (stb.idx == IDX_FAULT) faultQ <= merge(stb.op, faultQ, stb.data);
      if (stb.idx == IDX_CTL)   ctlQ   <= merge(stb.op, ctlQ, stb.data);
      if (stb.idx == IDX_BASE && stb.op == OP_LOAD) baseQ <= stb.data & BASE_KEEP;
      if (stb.idx == IDX_SEC  && stb.op == OP_LOAD) secQ  <= stb.data & SEC_MASK;
    end
  end

  for (genvar g = 0; g < NUM_PLAIN; g++) begin : gPlain
    always_ff @(posedge clk) begin
      if (!rstN)
        plainQ[g] <= '0;
      else if (stb.take && stb.op == OP_LOAD && stb.idx == PLAIN_IDX[g])
        plainQ[g] <= stb.data;
    end
  end

  always_comb begin
    readVal = '1;
    for (int i = 0; i < NUM_PLAIN; i++)
      if (stb.idx == PLAIN_IDX[i]) readVal = plainQ[i];
    unique case (stb.idx)
      IDX_FAULT: readVal = faultQ;
      IDX_BASE:  readVal = baseQ;
      IDX_SEC:   readVal = secQ;
      IDX_CTL:   readVal = ctlQ;
      IDX_STAT:  readVal = '0;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdQ <= '0;
    else if (stb.take)  rdQ <= stb.rd ? readVal : '0;
  end

  assign baseAddr = baseQ & BASE_MASK;
  assign baseEn   = baseQ[BASE_EN_BIT];

  // R5: enable output follows bit 0 of an accepted base load
  a_r5_enable_follows: assert property (@(posedge clk) disable iff (!rstN)
    (stb.take && stb.op == OP_LOAD && stb.idx == IDX_BASE) |=> (baseEn == $past(stb.data[0])));
  // R6: base register moves only on a load strobe
  a_r6_base_held: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.take && stb.op == OP_LOAD && stb.idx == IDX_BASE) |=> $stable(baseQ));
  // R8: alias indices read back as all ones
  a_r8_alias_read_ones: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && (stb.idx == IDX_FAULT_AND || stb.idx == IDX_FAULT_OR ||
                stb.idx == IDX_CTL_SET || stb.idx == IDX_CTL_CLR)) |=> (&rdQ));
  // R9: status register reads zero
  a_r9_stat_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && stb.idx == IDX_STAT) |=> (rdQ == '0));

endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int                SB_ADDR_W  = 8,
  parameter int                MM_ADDR_W  = 7,
  parameter logic [DATA_W-1:0] BASE_RESET = 64'h0000_0001_2340_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sbValid,
  output logic                 sbReady,
  input  logic                 sbWrite,
  input  logic [SB_ADDR_W-1:0] sbAddr,
  input  logic [DATA_W-1:0]    sbWdata,
  output logic                 sbAck,
  output logic [DATA_W-1:0]    sbRdata,
  output logic                 sbErr,
  input  logic                 mmValid,
  output logic                 mmReady,
  input  logic                 mmWrite,
  input  logic [MM_ADDR_W-1:0] mmAddr,
  input  logic [DATA_W-1:0]    mmWdata,
  output logic                 mmAck,
  output logic [DATA_W-1:0]    mmRdata,
  output logic                 mmErr,
  output logic [DATA_W-1:0]    baseAddr,
  output logic                 baseEn
);

  strobe_t           stb;
  logic [DATA_W-1:0] rdQ;

  regbank_ctrl #(.SB_ADDR_W(SB_ADDR_W), .MM_ADDR_W(MM_ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sbValid(sbValid), .sbWrite(sbWrite), .sbAddr(sbAddr), .sbWdata(sbWdata),
    .mmValid(mmValid), .mmWrite(mmWrite), .mmAddr(mmAddr), .mmWdata(mmWdata),
    .sbReady(sbReady), .mmReady(mmReady), .stb(stb),
    .sbAck(sbAck), .mmAck(mmAck), .sbErr(sbErr), .mmErr(mmErr)
  );

  regbank_regs #(.BASE_RESET(BASE_RESET)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .rdQ(rdQ),
    .baseAddr(baseAddr), .baseEn(baseEn)
  );

  assign sbRdata = sbAck ? rdQ : '0;
  assign mmRdata = mmAck ? rdQ : '0;

endmodule

// File: tb/regbank_top_tb.sv
module regbank_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sbValid = 1'b0, sbWrite = 1'b0, mmValid = 1'b0, mmWrite = 1'b0;
  logic [7:0]  sbAddr = '0;
  logic [6:0]  mmAddr = '0;
  logic [63:0] sbWdata = '0, mmWdata = '0;
  logic        sbReady, mmReady, sbAck, mmAck, sbErr, mmErr, baseEn;
  logic [63:0] sbRdata, mmRdata, baseAddr;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  bit          expPort [$];
  logic [63:0] expData [$];
  bit          expErr  [$];
  string       expTag  [$];

  always #10 clk = ~clk;  // 50 MHz

  regbank_top u_dut (
    .clk(clk), .rstN(rstN),
    .sbValid(sbValid), .sbReady(sbReady), .sbWrite(sbWrite), .sbAddr(sbAddr),
    .sbWdata(sbWdata), .sbAck(sbAck), .sbRdata(sbRdata), .sbErr(sbErr),
    .mmValid(mmValid), .mmReady(mmReady), .mmWrite(mmWrite), .mmAddr(mmAddr),
    .mmWdata(mmWdata), .mmAck(mmAck), .mmRdata(mmRdata), .mmErr(mmErr),
    .baseAddr(baseAddr), .baseEn(baseEn)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: pops expected responses as acknowledges appear
  always @(negedge clk) begin
    if (rstN && !done && (sbAck || mmAck)) begin
      chk("R10", "single ack", {63'd0, sbAck & mmAck}, 64'd0);
      if (expPort.size() == 0) begin
        chk("R10", "unexpected ack", 64'd1, 64'd0);
      end else begin
        automatic bit    p = expPort.pop_front();
        automatic logic [63:0] d = expData.pop_front();
        automatic bit    e = expErr.pop_front();
        automatic string t = expTag.pop_front();
        chk(t, "ack port", {63'd0, mmAck}, {63'd0, p});
        chk(t, "rdata", p ? mmRdata : sbRdata, d);
        chk(t, "err", {63'd0, p ? mmErr : sbErr}, {63'd0, e});
      end
    end
  end

  task automatic push(input bit p, input logic [63:0] d, input bit e, input string t);
    expPort.push_back(p); expData.push_back(d); expErr.push_back(e); expTag.push_back(t);
  endtask

  // driver: one access on one port; port 0 = sideband, 1 = mapped
  task automatic acc(input bit port, input bit wr, input logic [7:0] a,
                     input logic [63:0] d, input logic [63:0] expD,
                     input bit expE, input string tag);
    push(port, expD, expE, tag);
    @(negedge clk);
    if (!port) begin
      sbValid = 1'b1; sbWrite = wr; sbAddr = a; sbWdata = d;
    end else begin
      mmValid = 1'b1; mmWrite = wr; mmAddr = a[6:0]; mmWdata = d;
    end
    @(posedge clk);
    @(negedge clk);
    sbValid = 1'b0; mmValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "baseEn", {63'd0, baseEn}, 64'd1);
    chk("R1", "baseAddr", baseAddr, 64'h0000_0001_2340_0000);
    chk("R1", "no ack", {62'd0, sbAck, mmAck}, 64'd0);
    chk("R10", "sbReady", {63'd0, sbReady}, 64'd1);
    chk("R10", "mmReady", {63'd0, mmReady}, 64'd1);
    acc(0, 0, 8'h00, '0, 64'h0, 0, "R1");
    acc(0, 0, 8'h50, '0, 64'h0000_0001_2340_0001, 0, "R1");
    acc(1, 0, 8'h00, '0, 64'h0000_0001_2340_0001, 0, "R2");
    acc(1, 0, 8'h20, '0, 64'h0, 0, "R2");

    // R3 fault register and its aliases
    acc(0, 1, 8'h00, 64'hF0F0_0000_0000_00FF, 64'h0, 0, "R3");
    acc(0, 0, 8'h00, '0, 64'hF0F0_0000_0000_00FF, 0, "R3");
    acc(0, 1, 8'h08, 64'hFF00_0000_0000_000F, 64'h0, 0, "R3");
    acc(0, 0, 8'h00, '0, 64'hF000_0000_0000_000F, 0, "R3");
    acc(0, 1, 8'h10, 64'h0000_0000_1200_0000, 64'h0, 0, "R3");
    acc(0, 0, 8'h00, '0, 64'hF000_0000_1200_000F, 0, "R3");

    // R4 control register through the mapped port
    acc(1, 1, 8'h20, 64'h8400_0000_0000_0000, 64'h0, 0, "R4");
    acc(1, 1, 8'h40, 64'h0000_8000_0000_0001, 64'h0, 0, "R4");
    acc(0, 0, 8'h70, '0, 64'h8400_8000_0000_0001, 0, "R4");
    acc(1, 1, 8'h48, 64'h8000_0000_0000_0001, 64'h0, 0, "R4");
    acc(0, 0, 8'h70, '0, 64'h0400_8000_0000_0000, 0, "R4");

    // R5 base register masking and outputs
    acc(0, 1, 8'h50, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 0, "R5");
    chk("R5", "baseEn", {63'd0, baseEn}, 64'd0);
    chk("R5", "baseAddr", baseAddr, 64'h0003_FFFF_FFF0_0000);
    acc(0, 0, 8'h50, '0, 64'h0003_FFFF_FFF0_0000, 0, "R5");
    acc(0, 1, 8'h50, 64'h0000_0002_0000_0001, 64'h0, 0, "R5");
    chk("R5", "baseEn", {63'd0, baseEn}, 64'd1);
    chk("R5", "baseAddr", baseAddr, 64'h0000_0002_0000_0000);

    // R6 mapped write of base is rejected
    acc(1, 1, 8'h00, 64'h0000_0003_0000_0000, 64'h0, 1, "R6");
    chk("R6", "baseEn", {63'd0, baseEn}, 64'd1);
    chk("R6", "baseAddr", baseAddr, 64'h0000_0002_0000_0000);
    acc(0, 0, 8'h50, '0, 64'h0000_0002_0000_0001, 0, "R6");

    // R7 secondary base mask
    acc(0, 1, 8'h58, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, "R7");
    acc(0, 0, 8'h58, '0, 64'h0003_FFFF_0000_0000, 0, "R7");
    acc(1, 0, 8'h08, '0, 64'h0003_FFFF_0000_0000, 0, "R7");

    // R8 unimplemented and alias reads, ignored writes
    acc(0, 0, 8'h08, '0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8");
    acc(0, 0, 8'h10, '0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8");
    acc(1, 0, 8'h40, '0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8");
    acc(0, 0, 8'h18, '0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8");
    acc(0, 0, 8'hF8, '0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8");
    acc(1, 0, 8'h78, '0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8");
    acc(0, 1, 8'h18, 64'h1234_5678_9ABC_DEF0, 64'h0, 0, "R8");
    acc(0, 0, 8'h18, '0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8");
    acc(0, 0, 8'h00, '0, 64'hF000_0000_1200_000F, 0, "R8");
    acc(0, 0, 8'h70, '0, 64'h0400_8000_0000_0000, 0, "R8");

    // R9 status register is read-only
    acc(0, 1, 8'hA8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, "R9");
    acc(1, 1, 8'h58, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, "R9");
    acc(0, 0, 8'hA8, '0, 64'h0, 0, "R9");

    // R12 general registers
    acc(0, 1, 8'h30, 64'hA5A5_0000_FFFF_1234, 64'h0, 0, "R12");
    acc(0, 1, 8'h38, 64'h0123_4567_89AB_CDEF, 64'h0, 0, "R12");
    acc(1, 1, 8'h28, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 0, "R12");
    acc(1, 1, 8'h50, 64'h8000_0000_0000_0001, 64'h0, 0, "R12");
    acc(0, 0, 8'h30, '0, 64'hA5A5_0000_FFFF_1234, 0, "R12");
    acc(0, 0, 8'h38, '0, 64'h0123_4567_89AB_CDEF, 0, "R12");
    acc(0, 0, 8'h78, '0, 64'hDEAD_BEEF_CAFE_F00D, 0, "R12");
    acc(1, 0, 8'h50, '0, 64'h8000_0000_0000_0001, 0, "R12");

    // R10 conflict: sideband write wins, mapped read follows and sees it
    push(0, 64'h0, 0, "R10");
    push(1, 64'h1357_9BDF_0246_8ACE, 0, "R10");
    @(negedge clk);
    sbValid = 1'b1; sbWrite = 1'b1; sbAddr = 8'h78; sbWdata = 64'h1357_9BDF_0246_8ACE;
    mmValid = 1'b1; mmWrite = 1'b0; mmAddr = 7'h28; mmWdata = '0;
    #1 chk("R10", "mmReady in conflict", {63'd0, mmReady}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    sbValid = 1'b0;
    #1 chk("R10", "mmReady after conflict", {63'd0, mmReady}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    mmValid = 1'b0;

    repeat (3) @(negedge clk);
    chk("R10", "responses outstanding", 64'(expPort.size()), 64'd0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule